// File: doc/BRIEF.md
# Extended State Save Sequencer

This block orders the memory writes of a processor-state save. A one-cycle start pulse captures a 64-bit enable register, a request mask assembled from the low halves of two 64-bit source registers, the in-use vector and the header's old state-valid field. The block ANDs the enable register with the mask to form a feature bitmap. It then issues one write command per selected state area on a valid/ready command port, and ends with a header write that carries the merged state-valid field.

Each command names an area kind and the region it targets. The data payload, the memory model and fault detection are handled elsewhere. The block only decides which writes happen, in what order, and what the new header value is. A single-cycle done pulse marks the end of a save.

Top module: `xstate_save_seq`

## Requirements
- R1: The feature bitmap equals enable AND {hi_src[31:0], lo_src[31:0]}. Bits 63:32 of both source registers have no effect on commands or on the header value.
- R2: When bitmap bit 0 is set, a command with kind 0 (floating-point stack state) and region 0 (legacy) is issued.
- R3: When bitmap bit 1 is set, a command with kind 1 (vector registers) and region 0 (legacy) is issued.
- R4: When bitmap bit 2 is set, a command with kind 3 (wide vector state) and region 1 (extended) is issued.
- R5: A command with kind 2 (control/status word and its mask) and region 0 is issued when bitmap bit 1 or bit 2 is set, and is not issued otherwise.
- R6: Commands leave in ascending kind order 0, 1, 2, 3. Each save ends with exactly one header command with kind 4 and region 2. Bitmap bits above bit 2 produce no data command.
- R7: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and the kind and region stay unchanged.
- R8: While the header command is presented, new_hdr equals (old_hdr AND NOT bitmap) OR (in_use AND bitmap), using the values captured at start.
- R9: A bitmap of all zeros issues only the header command, with new_hdr equal to old_hdr, and then signals done.
- R10: done is high for exactly one cycle, the cycle after the header command is accepted, and at no other time.
- R11: A start pulse that arrives while a save is in progress changes neither the command stream nor the header value.
- R12: After reset, cmd_valid and done are low and new_hdr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; inputs are captured in the same cycle |
| feat_en_i | input | 64 | Enable register |
| mask_hi_src_i | input | 64 | Source of mask bits 63:32 (only bits 31:0 are used) |
| mask_lo_src_i | input | 64 | Source of mask bits 31:0 (only bits 31:0 are used) |
| in_use_i | input | 64 | In-use vector |
| old_hdr_i | input | 64 | Old header state-valid field |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command accepted when high with cmd_valid |
| cmd_kind_o | output | 3 | Area kind: 0 stack, 1 vector, 2 control/status, 3 wide vector, 4 header |
| cmd_region_o | output | 2 | Region: 0 legacy, 1 extended, 2 header |
| done_o | output | 1 | One-cycle pulse at the end of a save |
| new_hdr_o | output | 64 | Merged state-valid field for the header write |

## Verification
A scoreboard predicts the command list and the header value for each save. The saves cover single bits 0, 1 and 2, which separate the per-area rules and the shared control/status rule. They also cover all three low bits together, to check ordering, and an all-zero bitmap. Some saves set only upper bitmap bits, which must change the header merge but emit no data command. Junk in the ignored upper halves of the source registers and enable bits that clear requested mask bits test the AND. A ready line that is held low or varied pseudo-randomly tests the hold rule, and a start pulse sent mid-save tests that a busy block ignores it.

// File: rtl/xss_pkg.sv
package xss_pkg;

    localparam int NUM_STEPS = 5;
    localparam int STEP_W    = 3;

    typedef enum logic [STEP_W-1:0] {
        STEP_STACK = 3'd0,
        STEP_VEC   = 3'd1,
        STEP_CTRL  = 3'd2,
        STEP_WIDE  = 3'd3,
        STEP_HDR   = 3'd4
    } step_e;

    typedef enum logic [1:0] {
        AREA_LEGACY = 2'd0,
        AREA_EXT    = 2'd1,
        AREA_HDR    = 2'd2
    } area_e;

    function automatic area_e area_of(step_e s);
        case (s)
            STEP_WIDE: area_of = AREA_EXT;
            STEP_HDR:  area_of = AREA_HDR;
            default:   area_of = AREA_LEGACY;
        endcase
    endfunction

    // Steps to run for the three low bitmap bits; the header step always runs.
    function automatic logic [NUM_STEPS-1:0] steps_needed(logic [2:0] b);
        steps_needed[STEP_STACK] = b[0];
        steps_needed[STEP_VEC]   = b[1];
        steps_needed[STEP_CTRL]  = b[1] | b[2];
        steps_needed[STEP_WIDE]  = b[2];
        steps_needed[STEP_HDR]   = 1'b1;
    endfunction

endpackage

// File: rtl/xss_req_capture.sv
module xss_req_capture #(
    parameter int MASK_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic [MASK_W-1:0] en_i,
    input  logic [MASK_W-1:0] hi_src_i,
    input  logic [MASK_W-1:0] lo_src_i,
    input  logic [MASK_W-1:0] in_use_i,
    input  logic [MASK_W-1:0] old_i,
    output logic [MASK_W-1:0] bm_now_o,
    output logic [MASK_W-1:0] bm_q_o,
    output logic [MASK_W-1:0] in_use_q_o,
    output logic [MASK_W-1:0] old_q_o
);
    localparam int HALF = MASK_W / 2;

    assign bm_now_o = en_i & {hi_src_i[HALF-1:0], lo_src_i[HALF-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            bm_q_o     <= '0;
            in_use_q_o <= '0;
            old_q_o    <= '0;
        end else if (take_i) begin
            bm_q_o     <= bm_now_o;
            in_use_q_o <= in_use_i;
            old_q_o    <= old_i;
        end
    end

    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> ($stable(bm_q_o) && $stable(old_q_o) && $stable(in_use_q_o))); // R11

endmodule

// File: rtl/xss_hdr_merge.sv
module xss_hdr_merge #(
    parameter int MASK_W = 64
) (
    input  logic [MASK_W-1:0] old_i,
    input  logic [MASK_W-1:0] in_use_i,
    input  logic [MASK_W-1:0] bm_i,
    output logic [MASK_W-1:0] hdr_o
);
    always_comb begin
        hdr_o = (old_i & ~bm_i) | (in_use_i & bm_i);
    end
endmodule

// File: rtl/xss_cmd_seq.sv
module xss_cmd_seq
    import xss_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load_i,
    input  logic [2:0]  low_bits_i,
    input  logic        ready_i,
    output logic        busy_o,
    output logic        valid_o,
    output step_e       kind_o,
    output area_e       area_o,
    output logic        done_o
);
    logic [NUM_STEPS-1:0] pend_q;
    logic [STEP_W-1:0]    cur;
    logic                 fire;

    // Lowest pending step goes first, which yields the fixed order.
    always_comb begin
        cur = '0;
        for (int i = NUM_STEPS - 1; i >= 0; i--) begin
            if (pend_q[i]) cur = STEP_W'(i);
        end
    end

    assign busy_o  = |pend_q;
    assign valid_o = busy_o;
    assign kind_o  = step_e'(cur);
    assign area_o  = area_of(kind_o);
    assign fire    = valid_o & ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= fire && (kind_o == STEP_HDR);
            if (load_i) begin
                pend_q <= steps_needed(low_bits_i);
            end else if (fire) begin
                pend_q[cur] <= 1'b0;
            end
        end
    end

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ready_i) |=> (valid_o && $stable(kind_o) && $stable(area_o))); // R7

    AST_ASCENDING_ORDER: assert property (@(posedge clk) disable iff (rst)
        (fire && kind_o != STEP_HDR) |=> (valid_o && kind_o > $past(kind_o))); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10

    AST_DONE_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(fire && kind_o == STEP_HDR)); // R10

endmodule

// File: rtl/xstate_save_seq.sv
module xstate_save_seq
    import xss_pkg::*;
#(
    parameter int MASK_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [MASK_W-1:0] feat_en_i,
    input  logic [MASK_W-1:0] mask_hi_src_i,
    input  logic [MASK_W-1:0] mask_lo_src_i,
    input  logic [MASK_W-1:0] in_use_i,
    input  logic [MASK_W-1:0] old_hdr_i,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [2:0]        cmd_kind_o,
    output logic [1:0]        cmd_region_o,
    output logic              done_o,
    output logic [MASK_W-1:0] new_hdr_o
);
    logic              busy;
    logic              take;
    logic [MASK_W-1:0] bm_now, bm_q, in_use_q, old_q;
    step_e             kind;
    area_e             area;

    assign take = start_i & ~busy;

    xss_req_capture #(.MASK_W(MASK_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .take_i     (take),
        .en_i       (feat_en_i),
        .hi_src_i   (mask_hi_src_i),
        .lo_src_i   (mask_lo_src_i),
        .in_use_i   (in_use_i),
        .old_i      (old_hdr_i),
        .bm_now_o   (bm_now),
        .bm_q_o     (bm_q),
        .in_use_q_o (in_use_q),
        .old_q_o    (old_q)
    );

    xss_cmd_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .load_i     (take),
        .low_bits_i (bm_now[2:0]),
        .ready_i    (cmd_ready_i),
        .busy_o     (busy),
        .valid_o    (cmd_valid_o),
        .kind_o     (kind),
        .area_o     (area),
        .done_o     (done_o)
    );

    xss_hdr_merge #(.MASK_W(MASK_W)) u_merge (
        .old_i    (old_q),
        .in_use_i (in_use_q),
        .bm_i     (bm_q),
        .hdr_o    (new_hdr_o)
    );

    assign cmd_kind_o   = kind;
    assign cmd_region_o = area;

    AST_HDR_STABLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && !(cmd_ready_i && kind == STEP_HDR)) |=> $stable(new_hdr_o)); // R8

    AST_HDR_REGION: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && kind == STEP_HDR) |-> (area == AREA_HDR)); // R6

endmodule

// File: tb/xstate_save_seq_tb_top.sv
`timescale 1ns/1ps
module xstate_save_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] en = '0, hi = '0, lo = '0, inuse = '0, old = '0;
    logic        cmd_valid, cmd_ready = 1'b0, done;
    logic [2:0]  kind;
    logic [1:0]  region;
    logic [63:0] new_hdr;

    int checks = 0, errors = 0;
    int ops_done = 0, exp_done = 0;
    int ready_mode = 1;
    logic [15:0] lfsr = 16'hACE1;
    logic [68:0] expq[$];

    always #10 clk = ~clk;

    xstate_save_seq dut_i (
        .clk(clk), .rst(rst), .start_i(start), .feat_en_i(en),
        .mask_hi_src_i(hi), .mask_lo_src_i(lo), .in_use_i(inuse), .old_hdr_i(old),
        .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_kind_o(kind),
        .cmd_region_o(region), .done_o(done), .new_hdr_o(new_hdr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Ready driver, changes just after each rising edge.
    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ready_mode)
            0: cmd_ready = 1'b0;
            1: cmd_ready = 1'b1;
            default: cmd_ready = lfsr[0] | lfsr[3];
        endcase
    end

    // Monitor: compare each accepted command with the scoreboard.
    logic       stall_prev = 1'b0;
    logic [2:0] stall_kind = '0;
    logic       hdr_fired_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (stall_prev) begin
                check(cmd_valid && kind == stall_kind, "R7 hold", {61'd0, kind}, {61'd0, stall_kind});
            end
            check(done == hdr_fired_prev, "R10 done timing", {63'd0, done}, {63'd0, hdr_fired_prev});
            if (done) ops_done++;
            hdr_fired_prev = 1'b0;
            if (cmd_valid && cmd_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R11 unexpected command", {61'd0, kind}, 64'd0);
                end else begin
                    logic [68:0] e;
                    e = expq.pop_front();
                    check(kind == e[68:66], "R6 kind order", {61'd0, kind}, {61'd0, e[68:66]});
                    check(region == e[65:64], "R2-R5 region", {62'd0, region}, {62'd0, e[65:64]});
                    if (e[68:66] == 3'd4) begin
                        check(new_hdr == e[63:0], "R8 header merge", new_hdr, e[63:0]);
                        hdr_fired_prev = 1'b1;
                    end
                end
            end
            stall_prev = cmd_valid && !cmd_ready;
            stall_kind = kind;
        end
    end

    task automatic predict(input logic [63:0] e_en, e_hi, e_lo, e_in, e_old);
        logic [63:0] bm;
        bm = e_en & {e_hi[31:0], e_lo[31:0]};       // R1
        if (bm[0]) expq.push_back({3'd0, 2'd0, 64'd0});          // R2
        if (bm[1]) expq.push_back({3'd1, 2'd0, 64'd0});          // R3
        if (bm[1] | bm[2]) expq.push_back({3'd2, 2'd0, 64'd0});  // R5
        if (bm[2]) expq.push_back({3'd3, 2'd1, 64'd0});          // R4
        expq.push_back({3'd4, 2'd2, (e_old & ~bm) | (e_in & bm)});
    endtask

    task automatic pulse_start(input logic [63:0] p_en, p_hi, p_lo, p_in, p_old);
        @(posedge clk); #2;
        en = p_en; hi = p_hi; lo = p_lo; inuse = p_in; old = p_old; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic run_op(input logic [63:0] p_en, p_hi, p_lo, p_in, p_old);
        predict(p_en, p_hi, p_lo, p_in, p_old);
        exp_done++;
        pulse_start(p_en, p_hi, p_lo, p_in, p_old);
        wait (ops_done == exp_done);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check(cmd_valid == 1'b0, "R12 valid", {63'd0, cmd_valid}, 64'd0);
        check(done == 1'b0, "R12 done", {63'd0, done}, 64'd0);
        check(new_hdr == 64'd0, "R12 header", new_hdr, 64'd0);

        ready_mode = 1;
        run_op('1, 64'hFFFF_0000_0000_0000, 64'h1, 64'h5, 64'hA0);            // R2 alone
        run_op('1, 64'h0, 64'h2, 64'h0, 64'hFF);                               // R3 alone
        run_op('1, 64'h0, 64'h4, 64'h4, 64'h0);                                // R4 alone, R5
        run_op('1, 64'h8000_0001, 64'hDEAD_BEEF_0000_0007, 64'hF0F0, 64'h0F0F); // R6 all, R1
        run_op('0, '1, '1, '1, 64'h1234);                                      // R9 enable zero
        run_op(64'hFFFF_FFFF_FFFF_FFF8, '1, '1, 64'h0, '1);                    // R6 upper only
        run_op(64'h5, 64'h0, 64'h7, 64'h7, 64'h2);                             // R1 enable gating
        ready_mode = 2;
        for (int i = 0; i < 12; i++) begin
            run_op({lfsr, lfsr, lfsr, lfsr}, {lfsr, 48'h1}, {lfsr, 48'h0} | 64'(i),
                   {lfsr, ~lfsr, lfsr, ~lfsr}, {4{lfsr ^ 16'(i)}});             // R7 random stalls
        end

        // R11: second start while stalled must be ignored.
        ready_mode = 0;
        predict('1, 64'h0, 64'h3, 64'h3, 64'h0);
        exp_done++;
        pulse_start('1, 64'h0, 64'h3, 64'h3, 64'h0);
        repeat (3) @(posedge clk);
        pulse_start('1, 64'hFFFF, 64'h4, 64'h0, '1);
        repeat (3) @(posedge clk);
        ready_mode = 1;
        wait (ops_done == exp_done);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(expq.size() == 0, "R11 scoreboard drained", 64'(expq.size()), 64'd0);
        check(ops_done == 20, "R10 done count", 64'(ops_done), 64'd20);
        finish_run();
    end
endmodule